// File: doc/BRIEF.md
# Cascadable Dual-Mode PWM Timer Channel

This block is one timer channel that runs in one of two modes. As a divider, a 16-bit counter reloads from the compare value each time it reaches zero and flips its output on every reload. As a PWM generator, the low byte of the compare value sets the length of the high phase and the high byte sets the length of the low phase. The two phases repeat without a gap.

The counter takes one step per tick. A tick is either every module clock, or each rising and each falling edge of a trigger input. The trigger comes either from a neighbouring channel's timer output or from an external line. Feeding a divider channel into a PWM channel stretches every PWM tick by the divider ratio. This gives PWM periods far longer than two 8-bit phase counts allow on the module clock alone.

The trigger passes through a two-flop synchronizer before edge detection. Compare words are taken only at reload boundaries, so a phase already in progress is never cut short.

Top module: `pwm_timer_chan`

## Requirements
- R1: Configuration bits cfg[1:0] select the mode: 2'b11 is the 16-bit divider, 2'b10 is the 8+8-bit PWM mode, and any other code keeps the timer output low.
- R2: In divider mode the timer output flips every cmp[15:0]+1 ticks. With ticks on every clock the output period is 2*(cmp+1) clocks.
- R3: In PWM mode the output is high for cmp[7:0]+1 ticks, then low for cmp[15:8]+1 ticks, and this repeats.
- R4: Full duty is not reachable. With cmp = 16'h00FF the output is high for 256 ticks and low for 1 tick.
- R5: Bits cfg[3:2] select the tick source: 2'b00 ticks on every clock, 2'b01 ticks on both edges of the trigger. Bit cfg[4] = 1 takes the trigger from trig_int, and cfg[4] = 0 takes it from trig_ext.
- R6: When a PWM channel is cascaded behind a divider with compare K, each PWM phase lasts (phase count)*(K+1) clocks.
- R7: Bits cfg[6:5] = 2'b11 drive the timer output onto pin_out. Any other code holds pin_out low while the timer keeps running.
- R8: While enable is low the timer output is low and the counter is cleared. After enable rises in PWM mode, the output goes high at the next clock edge and stays high for cmp[7:0]+1 clocks when ticks run on every clock.
- R9: The compare value is taken only when a PWM period starts. A change in the middle of a period leaves the remaining high phase and the following low phase at their old lengths.
- R10: When no tick occurs, the counter and the timer output hold their values. An idle trigger therefore freezes the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable |
| cfg | input | 32 | Channel configuration word (mode, tick source, trigger select, pin config) |
| cmp | input | 16 | Compare value |
| trig_ext | input | 1 | External trigger line |
| trig_int | input | 1 | Trigger from another channel's timer output |
| tmr_out | output | 1 | Timer output, usable as a trigger for another channel |
| pin_out | output | 1 | Gated pin output |

## Verification
The hardest case to reach is a compare change that lands inside a running PWM period. The bench watches pin_out, counts two clocks into a high phase, and then writes a new compare value. It then measures that high phase, the following low phase, and the next full period. A second hard case is the cascade. A divider instance drives the PWM instance's internal trigger, and the measured widths must come out as exact multiples of the divider ratio even though the synchronizer adds latency. Freezing is checked by holding the external trigger still, then toggling it slowly by hand and stepping the output one tick per edge.

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [31:0] cfg,
  input  logic [15:0] cmp,
  input  logic        trig_ext,
  input  logic        trig_int,
  output logic        tmr_out,
  output logic        pin_out
);
  localparam logic [1:0] MODE_DIV = 2'b11;
  localparam logic [1:0] MODE_PWM = 2'b10;
  localparam logic [1:0] SRC_CLK  = 2'b00;
  localparam logic [1:0] SRC_TRG  = 2'b01;

  logic [1:0] mode, src;
  logic       use_int, pin_en, active, trg, edge_tick, tick;
  logic [2:0] sync_q;
  logic [15:0] cnt;
  logic [7:0]  low_q;
  logic [1:0]  mode_q;
  logic        run, out_q;
  wire         unused_cfg = ^cfg[31:7];

  assign mode    = cfg[1:0];
  assign src     = cfg[3:2];
  assign use_int = cfg[4];
  assign pin_en  = (cfg[6:5] == 2'b11);
  assign active  = enable && (mode == MODE_DIV || mode == MODE_PWM);

  assign trg       = use_int ? trig_int : trig_ext;
  assign edge_tick = sync_q[2] ^ sync_q[1];
  assign tick      = (src == SRC_CLK) ? 1'b1 :
                     (src == SRC_TRG) ? edge_tick : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], trg};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cnt    <= '0;
      out_q  <= 1'b0;
      low_q  <= '0;
      mode_q <= '0;
    end else if (!active || (run && mode != mode_q)) begin
      run   <= 1'b0;
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (!run) begin
      run    <= 1'b1;
      mode_q <= mode;
      if (mode == MODE_PWM) begin
        cnt   <= {8'h00, cmp[7:0]};
        low_q <= cmp[15:8];
        out_q <= 1'b1;
      end else begin
        cnt   <= cmp;
        out_q <= 1'b0;
      end
    end else if (tick) begin
      if (mode_q == MODE_DIV) begin
        if (cnt == 16'd0) begin
          cnt   <= cmp;
          out_q <= ~out_q;
        end else begin
          cnt <= cnt - 16'd1;
        end
      end else begin
        if (cnt[7:0] == 8'd0) begin
          if (out_q) begin
            out_q <= 1'b0;
            cnt   <= {8'h00, low_q};
          end else begin
            out_q <= 1'b1;
            low_q <= cmp[15:8];
            cnt   <= {8'h00, cmp[7:0]};
          end
        end else begin
          cnt <= cnt - 16'd1;
        end
      end
    end
  end

  assign tmr_out = out_q;
  assign pin_out = out_q & pin_en;
endmodule

module pwm_timer_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic [1:0]  mode,
  input logic [1:0]  mode_q,
  input logic        run,
  input logic        tick,
  input logic [15:0] cnt,
  input logic        tmr_out
);
  p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tmr_out);

  p_start_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(enable) && mode == 2'b10) |=> tmr_out);

  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && enable && mode == mode_q && !tick) |=> ($stable(cnt) && $stable(tmr_out)));

  p_pwm_cnt_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == 2'b10) |-> (cnt[15:8] == 8'd0));
endmodule

bind pwm_timer_chan pwm_timer_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mode(cfg[1:0]), .mode_q(mode_q),
  .run(run), .tick(tick), .cnt(cnt), .tmr_out(tmr_out)
);

// File: tb/pwm_timer_chan_tb.sv
module pwm_timer_chan_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [31:0] cfg = '0, pre_cfg = '0;
  logic [15:0] cmp = '0, pre_cmp = '0;
  logic trig_ext = 1'b0;
  logic pre_tmr, pre_pin, tmr_out, pin_out;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_timer_chan u_pre (.clk(clk), .rst_n(rst_n), .enable(en), .cfg(pre_cfg), .cmp(pre_cmp),
    .trig_ext(1'b0), .trig_int(1'b0), .tmr_out(pre_tmr), .pin_out(pre_pin));

  pwm_timer_chan u_dut (.clk(clk), .rst_n(rst_n), .enable(en), .cfg(cfg), .cmp(cmp),
    .trig_ext(trig_ext), .trig_int(pre_tmr), .tmr_out(tmr_out), .pin_out(pin_out));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [31:0] c, input logic [15:0] v,
                         input logic [31:0] pc, input logic [15:0] pv);
    @(negedge clk); en = 1'b0;
    @(negedge clk); cfg = c; cmp = v; pre_cfg = pc; pre_cmp = pv;
    @(negedge clk); en = 1'b1;
  endtask

  task automatic wait_level(input logic lvl);
    int guard = 0;
    while (pin_out !== lvl && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (pin_out === lvl && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic measure(output int hi, output int lo);
    @(negedge clk);
    wait_level(1'b0);
    wait_level(1'b1);
    count_level(1'b1, hi);
    count_level(1'b0, lo);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(pin_out === 1'b0 && tmr_out === 1'b0, "R8 reset output", int'(tmr_out), 0);
  endtask

  task automatic t_idle_mode;
    int seen = 0;
    restart(32'h0000_0060, 16'h0101, 32'h0, 16'h0);
    repeat (40) begin @(negedge clk); if (tmr_out) seen++; end
    check(seen == 0, "R1 idle mode code keeps output low", seen, 0);
  endtask

  task automatic t_div16;
    int hi, lo;
    restart(32'h0000_0063, 16'd4, 32'h0, 16'h0);
    measure(hi, lo);
    check(hi == 5, "R2 divider high width", hi, 5);
    check(lo == 5, "R2 divider low width", lo, 5);
  endtask

  task automatic t_pwm_clk;
    int hi, lo;
    restart(32'h0000_0062, 16'h0203, 32'h0, 16'h0);
    measure(hi, lo);
    check(hi == 4, "R3 pwm high 0x0203", hi, 4);
    check(lo == 3, "R3 pwm low 0x0203", lo, 3);
    restart(32'h0000_0062, 16'h0004, 32'h0, 16'h0);
    measure(hi, lo);
    check(hi == 5, "R3 pwm high 0x0004", hi, 5);
    check(lo == 1, "R3 pwm low 0x0004", lo, 1);
  endtask

  task automatic t_full_duty;
    int hi, lo;
    restart(32'h0000_0062, 16'h00FF, 32'h0, 16'h0);
    measure(hi, lo);
    check(hi == 256, "R4 high 0x00FF", hi, 256);
    check(lo == 1, "R4 low 0x00FF", lo, 1);
  endtask

  task automatic t_start;
    int hi;
    restart(32'h0000_0062, 16'h0707, 32'h0, 16'h0);
    @(negedge clk);
    check(pin_out === 1'b1, "R8 output high after enable", int'(pin_out), 1);
    count_level(1'b1, hi);
    check(hi == 8, "R8 first high phase", hi, 8);
    @(negedge clk); en = 1'b0;
    @(negedge clk); @(negedge clk);
    check(tmr_out === 1'b0, "R8 output low when disabled", int'(tmr_out), 0);
  endtask

  task automatic t_pin_off;
    int pin_hi = 0, tmr_hi = 0;
    restart(32'h0000_0002, 16'h0303, 32'h0, 16'h0);
    repeat (40) begin
      @(negedge clk);
      if (pin_out) pin_hi++;
      if (tmr_out) tmr_hi++;
    end
    check(pin_hi == 0, "R7 pin held low", pin_hi, 0);
    check(tmr_hi == 20, "R7 timer still running", tmr_hi, 20);
  endtask

  task automatic t_hold;
    int low_seen = 0;
    restart(32'h0000_0066, 16'h0101, 32'h0, 16'h0);
    repeat (60) begin @(negedge clk); if (!pin_out) low_seen++; end
    check(low_seen == 0, "R10 idle trigger freezes output", low_seen, 0);
    trig_ext = 1'b1;
    repeat (6) @(negedge clk);
    check(pin_out === 1'b1, "R10 one edge one tick", int'(pin_out), 1);
    trig_ext = 1'b0;
    repeat (6) @(negedge clk);
    check(pin_out === 1'b0, "R5 second edge ends high phase", int'(pin_out), 0);
  endtask

  task automatic t_cascade(input logic [15:0] k, input logic [15:0] v,
                           input int exp_hi, input int exp_lo);
    int hi, lo;
    restart(32'h0000_0076, v, 32'h0000_0003, k);
    measure(hi, lo);
    check(hi == exp_hi, "R6 cascade high width", hi, exp_hi);
    check(lo == exp_lo, "R6 cascade low width", lo, exp_lo);
  endtask

  task automatic t_midchange;
    int h1 = 0, l1, h2, l2;
    restart(32'h0000_0062, 16'h0505, 32'h0, 16'h0);
    @(negedge clk);
    wait_level(1'b0);
    wait_level(1'b1);
    while (pin_out === 1'b1 && h1 < 5000) begin
      h1++;
      if (h1 == 2) cmp = 16'h0202;
      @(negedge clk);
    end
    count_level(1'b0, l1);
    count_level(1'b1, h2);
    count_level(1'b0, l2);
    check(h1 == 6, "R9 current high kept", h1, 6);
    check(l1 == 6, "R9 current low kept", l1, 6);
    check(h2 == 3, "R9 new high applied", h2, 3);
    check(l2 == 3, "R9 new low applied", l2, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle_mode();
    t_div16();
    t_pwm_clk();
    t_full_duty();
    t_start();
    t_pin_off();
    t_hold();
    t_cascade(16'd9, 16'h0004, 50, 10);
    t_cascade(16'd1, 16'h13B3, 360, 40);
    t_cascade(16'd1, 16'hB313, 40, 360);
    t_midchange();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule